// File: doc/BRIEF.md
# Gate driver protection controller

This block is the synchronous decision logic that sits beside an isolated power-switch gate driver. It watches a pair of complementary drive inputs, a fault-clear request, supply-low flags for both sides of the isolation barrier, an over-temperature enter/exit flag pair and the desaturation comparator. From these it decides, every clock, whether the gate may be commanded on. It also decides whether the driver must instead pull the gate down through its weak soft-shutdown path.

Desaturation is trusted only once a blanking window has passed after each turn-on. During that window, and whenever the gate is off, the blanking switch is held on. A desaturation seen after the window latches a fault. The latched fault removes the gate command, engages soft shutdown, and is shown on the active-low fault output after a fixed reporting delay. The fault can be removed only by holding the clear input low for a debounced minimum time. Supply and thermal status work through a separate, non-latching ready signal. All asynchronous inputs pass through two-flop synchronizers. Each timing window is a parameter counted in clock cycles.

Top module: `gate_prot_ctrl`

## Requirements
- R1: `gate_on` is high only when `drv_pos` is high, `drv_neg` is low, `clr_n` is high, `ready` is high and no fault is latched. A drive-input change reaches `gate_on` three clock edges after it is first sampled: two synchronizer stages and one output register.
- R2: `blank_on` is high whenever `gate_on` is low. After each rising edge of `gate_on` it stays high for MASK_CYC further cycles.
- R3: With `gate_on` high and `blank_on` low, a synchronized high on `desat` latches a fault. On the next edge `gate_on` falls and `soft_off` rises. A `desat` high while `blank_on` is high is ignored.
- R4: `fault_n` falls exactly RPT_CYC cycles after `soft_off` rises, and it never falls while `soft_off` is low.
- R5: While a fault is latched, `gate_on` stays low whatever the drive inputs do.
- R6: A synchronized low on `clr_n` lasting DEB_CYC consecutive cycles clears the fault, returning `soft_off` low and `fault_n` high on the same edge. A low lasting DEB_CYC-1 cycles leaves the fault, `soft_off` and `fault_n` unchanged.
- R7: While `clr_n` is low, `gate_on` is held low even with no fault latched. Drive resumes when `clr_n` returns high.
- R8: `ready` is low while `uv_pri` or `uv_sec` is high or the thermal-shutdown state is held. It returns high on its own, with no clear pulse, once all three are gone.
- R9: A high on `ot_enter` enters thermal shutdown. The state is held after `ot_enter` falls, until `ot_exit` is high while `ot_enter` is low.
- R10: During and just after `rst_n` low, `gate_on` is low, `blank_on` is high, `soft_off` is low and `fault_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| drv_pos | input | 1 | Non-inverted drive request |
| drv_neg | input | 1 | Inverted drive request (must be low to drive) |
| clr_n | input | 1 | Fault-clear request, active low; also blocks the gate while low |
| uv_pri | input | 1 | Input-side supply below its lockout threshold |
| uv_sec | input | 1 | Output-side supply below its lockout threshold |
| ot_enter | input | 1 | Temperature above the shutdown-entry point |
| ot_exit | input | 1 | Temperature below the shutdown-release point |
| desat | input | 1 | Desaturation comparator output |
| gate_on | output | 1 | Gate turn-on command |
| soft_off | output | 1 | Soft-shutdown path enable |
| blank_on | output | 1 | Blanking switch control, high clamps the sense node |
| fault_n | output | 1 | Reported fault, active low |
| ready | output | 1 | Supplies and temperature in range |

## Verification
The bench places desaturation pulses inside the blanking window, where a design that counted the mask from the wrong edge would trip falsely. It also places them just after the window, where an over-long mask would miss a genuine short circuit. Clear pulses one cycle shorter than, and exactly equal to, the debounce length separate an off-by-one counter that clears too early from one that never clears. The report delay is sampled one cycle before and at its expected edge, and drive toggling during a latched fault catches a gate that escapes the latch. Thermal enter and exit pulses check that ready is held by state, not by the enter flag's level. Random traffic is compared each cycle against a reference model.

// File: rtl/gp_pkg.sv
package gp_pkg;
    // bit positions on the synchronizer bus
    localparam int NSYNC   = 8;
    localparam int IX_POS  = 0;
    localparam int IX_NEG  = 1;
    localparam int IX_CLR  = 2;
    localparam int IX_UVP  = 3;
    localparam int IX_UVS  = 4;
    localparam int IX_OTE  = 5;
    localparam int IX_OTX  = 6;
    localparam int IX_DSAT = 7;

    typedef enum logic {
        TH_OK  = 1'b0,
        TH_HOT = 1'b1
    } therm_e;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gp_ready.sv
module gp_ready
    import gp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uv_pri,
    input  logic uv_sec,
    input  logic ot_enter,
    input  logic ot_exit,
    output logic ready
);
    typedef struct packed {
        therm_e th;
        logic   rdy;
    } rdy_t;

    rdy_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ot_enter)     st_d.th = TH_HOT;
        else if (ot_exit) st_d.th = TH_OK;
        st_d.rdy = !uv_pri && !uv_sec && (st_d.th == TH_OK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.th  <= TH_OK;
            st_q.rdy <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.rdy;

    // R8
    uv_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_pri || uv_sec) |=> !ready);
    // R9
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.th == TH_HOT && !ot_exit) |=> !ready);
endmodule

// File: rtl/gp_fault.sv
module gp_fault #(
    parameter int MASK_CYC = 39,
    parameter int DEB_CYC  = 63,
    parameter int RPT_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic desat,
    input  logic clr,
    output logic trip,
    output logic fault,
    output logic soft_off,
    output logic fault_n,
    output logic blank_on
);
    localparam int MW = $clog2(MASK_CYC + 1);
    localparam int DW = $clog2(DEB_CYC + 1);
    localparam int RW = $clog2(RPT_CYC + 1);

    typedef struct packed {
        logic [MW-1:0] mcnt;
        logic [DW-1:0] dcnt;
        logic [RW-1:0] rcnt;
        logic          flt;
        logic          rep;
    } flt_t;

    flt_t st_d, st_q;
    logic mask_done;
    logic deb_done;

    always_comb begin
        st_d      = st_q;
        mask_done = (st_q.mcnt == MW'(MASK_CYC));
        deb_done  = (st_q.dcnt == DW'(DEB_CYC));
        trip      = desat && gate && mask_done && !st_q.flt;

        // blanking mask timer restarts whenever the gate is off
        if (!gate)           st_d.mcnt = '0;
        else if (!mask_done) st_d.mcnt = st_q.mcnt + 1'b1;

        // clear-request debounce, saturating
        if (clr)            st_d.dcnt = '0;
        else if (!deb_done) st_d.dcnt = st_q.dcnt + 1'b1;

        // fault latch
        if (st_q.flt) st_d.flt = !deb_done;
        else          st_d.flt = trip;

        // report delay
        if (!st_q.flt)      st_d.rcnt = '0;
        else if (!st_q.rep) st_d.rcnt = st_q.rcnt + 1'b1;
        st_d.rep = st_d.flt &&
                   (st_q.rep || (st_q.flt && st_q.rcnt == RW'(RPT_CYC - 1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault    = st_q.flt;
    assign soft_off = st_q.flt;
    assign fault_n  = !st_q.rep;
    assign blank_on = !(gate && mask_done);

    // R2
    blank_at_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> blank_on);
    // R4
    report_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> soft_off);
    // R6
    clear_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flt) |-> !$past(clr, 2));
endmodule

// File: rtl/gate_prot_ctrl.sv
module gate_prot_ctrl
    import gp_pkg::*;
#(
    parameter int MASK_CYC = 39,
    parameter int DEB_CYC  = 63,
    parameter int RPT_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_pos,
    input  logic drv_neg,
    input  logic clr_n,
    input  logic uv_pri,
    input  logic uv_sec,
    input  logic ot_enter,
    input  logic ot_exit,
    input  logic desat,
    output logic gate_on,
    output logic soft_off,
    output logic blank_on,
    output logic fault_n,
    output logic ready
);
    typedef struct packed {
        logic gate;
    } top_t;

    logic [NSYNC-1:0] raw, syn;
    logic             trip, fault;
    top_t             st_d, st_q;

    always_comb begin
        raw           = '0;
        raw[IX_POS]   = drv_pos;
        raw[IX_NEG]   = drv_neg;
        raw[IX_CLR]   = clr_n;
        raw[IX_UVP]   = uv_pri;
        raw[IX_UVS]   = uv_sec;
        raw[IX_OTE]   = ot_enter;
        raw[IX_OTX]   = ot_exit;
        raw[IX_DSAT]  = desat;
    end

    gp_sync #(.W(NSYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (syn)
    );

    gp_ready u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_pri  (syn[IX_UVP]),
        .uv_sec  (syn[IX_UVS]),
        .ot_enter(syn[IX_OTE]),
        .ot_exit (syn[IX_OTX]),
        .ready   (ready)
    );

    gp_fault #(
        .MASK_CYC(MASK_CYC),
        .DEB_CYC (DEB_CYC),
        .RPT_CYC (RPT_CYC)
    ) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (st_q.gate),
        .desat   (syn[IX_DSAT]),
        .clr     (syn[IX_CLR]),
        .trip    (trip),
        .fault   (fault),
        .soft_off(soft_off),
        .fault_n (fault_n),
        .blank_on(blank_on)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gate = syn[IX_POS] && !syn[IX_NEG] && syn[IX_CLR] &&
                    ready && !fault && !trip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_on = st_q.gate;

    // R1
    gate_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> $past(syn[IX_POS] && !syn[IX_NEG] && syn[IX_CLR]));
    // R5
    fault_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_off |=> !gate_on);
    // R7
    clr_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !syn[IX_CLR] |=> !gate_on);
endmodule

// File: tb/gate_prot_ctrl_tb.sv
module gate_prot_ctrl_tb;
    localparam int MASK = 6;
    localparam int DEB  = 8;
    localparam int RPT  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_pos = 0, drv_neg = 0, clr_n = 1, uv_pri = 0, uv_sec = 0;
    logic ot_enter = 0, ot_exit = 0, desat = 0;
    logic gate_on, soft_off, blank_on, fault_n, ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    gate_prot_ctrl #(.MASK_CYC(MASK), .DEB_CYC(DEB), .RPT_CYC(RPT)) u_dut (
        .clk(clk), .rst_n(rst_n), .drv_pos(drv_pos), .drv_neg(drv_neg),
        .clr_n(clr_n), .uv_pri(uv_pri), .uv_sec(uv_sec), .ot_enter(ot_enter),
        .ot_exit(ot_exit), .desat(desat), .gate_on(gate_on), .soft_off(soft_off),
        .blank_on(blank_on), .fault_n(fault_n), .ready(ready)
    );

    // reference model built from the requirements
    logic [7:0] m1, m2;
    bit m_hot, m_rdy, m_g, m_f, m_rep;
    int m_mc, m_dc, m_rc;

    function automatic bit m_blank();
        return !(m_g && m_mc == MASK);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; m_hot = 0; m_rdy = 0; m_g = 0; m_f = 0; m_rep = 0;
            m_mc = 0; m_dc = 0; m_rc = 0;
        end else begin
            bit n_hot, n_rdy, n_g, n_f, n_rep, mdone, trip;
            int n_mc, n_dc, n_rc;
            n_hot = m2[5] ? 1'b1 : (m2[6] ? 1'b0 : m_hot);
            n_rdy = !m2[3] && !m2[4] && !n_hot;
            mdone = (m_mc == MASK);
            trip  = m2[7] && m_g && mdone && !m_f;
            n_g   = m2[0] && !m2[1] && m2[2] && m_rdy && !m_f && !trip;
            n_mc  = !m_g ? 0 : (mdone ? m_mc : m_mc + 1);
            n_dc  = m2[2] ? 0 : (m_dc == DEB ? m_dc : m_dc + 1);
            n_f   = m_f ? !(m_dc == DEB) : trip;
            n_rc  = !m_f ? 0 : (m_rep ? m_rc : m_rc + 1);
            n_rep = n_f && (m_rep || (m_f && m_rc == RPT - 1));
            m2 = m1;
            m1 = {desat, ot_exit, ot_enter, uv_sec, uv_pri, clr_n, drv_neg, drv_pos};
            m_hot = n_hot; m_rdy = n_rdy; m_g = n_g; m_f = n_f; m_rep = n_rep;
            m_mc = n_mc; m_dc = n_dc; m_rc = n_rc;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R1 gate_on model", gate_on, m_g);
        chk("R2 blank_on model", blank_on, m_blank());
        chk("R3 soft_off model", soft_off, m_f);
        chk("R4 fault_n model", fault_n, !m_rep);
        chk("R8 ready model", ready, m_rdy);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_model();
        end
    endtask

    int clr_left = 0;

    initial begin
        void'($urandom(32'h5eed_1234));
        // R10 reset state
        #1;
        chk("R10 gate low in reset", gate_on, 1'b0);
        chk("R10 blank high in reset", blank_on, 1'b1);
        chk("R10 soft_off low in reset", soft_off, 1'b0);
        chk("R10 fault_n high in reset", fault_n, 1'b1);
        step(3);
        rst_n = 1;
        step(6);
        chk("R10 no fault after reset", fault_n, 1'b1);
        chk("R8 ready after reset with clean flags", ready, 1'b1);

        // R1 drive on, R2 blank during mask, R3 desat in mask ignored
        drv_pos = 1;
        step(3);
        chk("R1 gate on after drive", gate_on, 1'b1);
        chk("R2 blank held after turn-on", blank_on, 1'b1);
        desat = 1;
        step(1);
        desat = 0;
        step(MASK + 4);
        chk("R3 desat inside mask ignored", soft_off, 1'b0);
        chk("R2 blank released after mask", blank_on, 1'b0);
        drv_neg = 1;
        step(3);
        chk("R1 inverted input blocks gate", gate_on, 1'b0);
        chk("R2 blank high while gate off", blank_on, 1'b1);
        drv_neg = 0;
        step(MASK + 6);

        // R3 fault latch, R4 report delay
        desat = 1;
        step(3);
        chk("R3 soft_off after desat", soft_off, 1'b1);
        chk("R3 gate dropped after desat", gate_on, 1'b0);
        desat = 0;
        step(RPT - 1);
        chk("R4 fault_n not yet reported", fault_n, 1'b1);
        step(1);
        chk("R4 fault_n reported", fault_n, 1'b0);

        // R5 drive ignored during fault
        for (int i = 0; i < 20; i++) begin
            drv_pos = i[0];
            drv_neg = i[2];
            step(1);
            chk("R5 gate held low in fault", gate_on, 1'b0);
        end
        drv_pos = 1; drv_neg = 0;

        // R6 short clear pulse
        clr_n = 0;
        step(DEB - 1);
        clr_n = 1;
        step(8);
        chk("R6 short clear keeps soft_off", soft_off, 1'b1);
        chk("R6 short clear keeps fault_n", fault_n, 1'b0);
        // R6 full clear pulse
        clr_n = 0;
        step(DEB);
        clr_n = 1;
        step(3);
        chk("R6 full clear drops soft_off", soft_off, 1'b0);
        chk("R6 full clear raises fault_n", fault_n, 1'b1);
        step(3);
        chk("R7 gate resumes after clear", gate_on, 1'b1);

        // R7 clear low blocks gate without fault
        clr_n = 0;
        step(3);
        chk("R7 clr low forces gate low", gate_on, 1'b0);
        chk("R7 no fault from clr low", soft_off, 1'b0);
        clr_n = 1;
        step(3);
        chk("R7 gate back when clr high", gate_on, 1'b1);

        // R8 undervoltage
        uv_sec = 1;
        step(4);
        chk("R8 ready low on uv_sec", ready, 1'b0);
        chk("R8 gate low on uv_sec", gate_on, 1'b0);
        uv_sec = 0;
        step(4);
        chk("R8 ready returns without clear", ready, 1'b1);

        // R9 thermal hold
        ot_enter = 1;
        step(1);
        ot_enter = 0;
        step(20);
        chk("R9 thermal state held", ready, 1'b0);
        ot_exit = 1;
        step(1);
        ot_exit = 0;
        step(4);
        chk("R9 thermal state released", ready, 1'b1);

        // random traffic against the model
        for (int c = 0; c < 6000; c++) begin
            if ($urandom % 8 == 0)   drv_pos = !drv_pos;
            if ($urandom % 40 == 0)  drv_neg = !drv_neg;
            desat = ($urandom % 12 == 0);
            if ($urandom % 300 == 0) uv_pri = 1; else if ($urandom % 20 == 0) uv_pri = 0;
            if ($urandom % 300 == 0) uv_sec = 1; else if ($urandom % 20 == 0) uv_sec = 0;
            ot_enter = ($urandom % 400 == 0);
            ot_exit  = ($urandom % 30 == 0);
            if (clr_left > 0) begin
                clr_left--;
                clr_n = (clr_left == 0);
            end else if ($urandom % 120 == 0) begin
                clr_left = 1 + int'($urandom % (2 * DEB));
                clr_n = 0;
            end
            step(1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule